// File: doc/BRIEF.md
# Multi-Source Interrupt Aggregator

This block collects a parameterised set of interrupt request lines, up to 32, and merges them into one registered interrupt output. Each source is first conditioned by its own polarity bit and trigger-type bit. The result is held in a pending bit. Pending bits are masked by per-source enable bits, ORed together, and registered onto the output.

Software reaches the block through a small word-indexed register port. Writes are a single-cycle strobe. Reads are combinational from the index. Through this port software identifies the block, learns how many sources exist, programs enables, polarity and trigger type, sets enable bits without a read-modify-write, acknowledges latched edges, and observes pending state before and after masking.

Top module: `irq_combiner`

## Requirements
- R1: Register word indexes are 0 identity code (read-only, value of parameter ID_CODE), 1 options, 2 enable (read/write), 3 enable-set (write-only, reads 0), 4 polarity (read/write), 5 trigger type (read/write), 6 acknowledge on write and raw pending on read, 7 masked pending (read-only); bit n of every per-source word belongs to source n.
- R2: The options word holds the number of implemented sources (1 to 32) in bits 5:0, with all other bits zero; control bits at or above that count read as zero and ignore writes.
- R3: After reset the enable, polarity and type words read zero and the interrupt output is low.
- R4: A polarity bit of 0 makes the source active-high (level) or rising-edge (edge); a polarity bit of 1 makes it active-low or falling-edge; a transition in the inactive direction sets nothing.
- R5: With its type bit at 1 (edge), a source sets its pending bit on the first clock edge after the active transition, and the bit stays set after the input returns inactive until it is acknowledged.
- R6: With its type bit at 0 (level), the pending bit equals the conditioned input as sampled at the previous clock edge, and an acknowledge has no effect while the input stays active.
- R7: Writing the acknowledge word clears the edge pending bits written as 1 at that clock edge; bits written as 0 are left unchanged.
- R8: Writing the enable-set word sets each enable bit written as 1 and leaves every other enable bit unchanged.
- R9: The output goes high on the clock edge after any pending bit meets a set enable bit, and goes low on the clock edge after none does; an input change therefore reaches the output two edges later.
- R10: The raw pending read shows pending bits regardless of enables; the masked read shows pending AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Interrupt request lines |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
On every cycle the assertions check that an edge pending bit holds until acknowledged and that an active transition always sets it. They also check that a level pending bit tracks the previous conditioned input, that an enable-set write never clears enables, and that the output follows the masked OR one edge later. Only the bench scenarios show the register map and the options value. The same is true of the end-to-end latency for each polarity and type combination, of opposite-direction transitions being ignored, of acknowledge having no hold on an active level source, and of writes to bits beyond the source count being dropped.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W = 32;
    localparam int IDX_W  = 3;

    typedef enum logic [IDX_W-1:0] {
        IX_IDENT = 3'd0,
        IX_CAPS  = 3'd1,
        IX_ENA   = 3'd2,
        IX_ENSET = 3'd3,
        IX_POL   = 3'd4,
        IX_TRIG  = 3'd5,
        IX_ACK   = 3'd6,
        IX_MASK  = 3'd7
    } reg_ix_e;

    typedef struct packed {
        logic              we;
        reg_ix_e           ix;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    function automatic logic [DATA_W-1:0] caps_word(input int unsigned n);
        logic [5:0] cnt;
        cnt = 6'(n);
        return DATA_W'(cnt);
    endfunction

endpackage

// File: rtl/irqc_src.sv
module irqc_src (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic low_act_i,
    input  logic edge_mode_i,
    input  logic ack_i,
    output logic pend_o
);
    logic req_q;
    logic cond_now;
    logic cond_old;
    logic act_edge;

    assign cond_now = req_i ^ low_act_i;
    assign cond_old = req_q ^ low_act_i;
    assign act_edge = cond_now & ~cond_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            pend_o <= 1'b0;
        end else begin
            req_q <= req_i;
            if (!edge_mode_i)
                pend_o <= cond_now;
            else if (act_edge)
                pend_o <= 1'b1;
            else if (ack_i)
                pend_o <= 1'b0;
        end
    end

    p_edge_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (edge_mode_i && pend_o && !ack_i) |=> pend_o);

    p_edge_set_r4: assert property (@(posedge clk) disable iff (rst)
        (edge_mode_i && (req_i ^ low_act_i) && !(req_q ^ low_act_i)) |=> pend_o);

    p_level_track_r6: assert property (@(posedge clk) disable iff (rst)
        (!edge_mode_i) |=> (pend_o == $past(req_i ^ low_act_i)));

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_wr_t            wr_i,
    output logic [NUM_SRC-1:0] ena_o,
    output logic [NUM_SRC-1:0] pol_o,
    output logic [NUM_SRC-1:0] trig_o,
    output logic [NUM_SRC-1:0] ack_o
);
    logic [NUM_SRC-1:0] wbits;
    assign wbits = wr_i.data[NUM_SRC-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ena_o  <= '0;
            pol_o  <= '0;
            trig_o <= '0;
        end else if (wr_i.we) begin
            case (wr_i.ix)
                IX_ENA:   ena_o  <= wbits;
                IX_ENSET: ena_o  <= ena_o | wbits;
                IX_POL:   pol_o  <= wbits;
                IX_TRIG:  trig_o <= wbits;
                default:  ;
            endcase
        end
    end

    assign ack_o = (wr_i.we && wr_i.ix == IX_ACK) ? wbits : '0;

    p_reset_clear_r3: assert property (@(posedge clk)
        rst |=> (ena_o == '0 && pol_o == '0 && trig_o == '0));

    p_enset_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_i.we && wr_i.ix == IX_ENSET) |=>
            (((ena_o & $past(ena_o)) == $past(ena_o)) &&
             ((ena_o & $past(wbits)) == $past(wbits))));

endmodule

// File: rtl/irqc_merge.sv
module irqc_merge #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] ena_i,
    output logic [NUM_SRC-1:0] masked_o,
    output logic               irq_o
);
    assign masked_o = pend_i & ena_i;

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |masked_o;
    end

    p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
        (|(pend_i & ena_i)) |=> irq_o);

    p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
        (!(|(pend_i & ena_i))) |=> !irq_o);

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import irqc_pkg::*;
#(
    parameter int          NUM_SRC = 32,
    parameter logic [31:0] ID_CODE = 32'h0A61_C0DE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               reg_we,
    input  logic [2:0]         reg_idx,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq_out
);
    localparam logic [DATA_W-1:0] CAPS = caps_word(NUM_SRC);

    bus_wr_t            wr;
    logic [NUM_SRC-1:0] ena, pol, trig, ack, pend, masked;

    initial begin
        if (NUM_SRC < 1 || NUM_SRC > 32)
            $error("NUM_SRC out of range");
    end

    assign wr.we   = reg_we;
    assign wr.ix   = reg_ix_e'(reg_idx);
    assign wr.data = reg_wdata;

    irqc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (wr),
        .ena_o  (ena),
        .pol_o  (pol),
        .trig_o (trig),
        .ack_o  (ack)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irqc_src u_src (
            .clk         (clk),
            .rst         (rst),
            .req_i       (irq_in[g]),
            .low_act_i   (pol[g]),
            .edge_mode_i (trig[g]),
            .ack_i       (ack[g]),
            .pend_o      (pend[g])
        );
    end

    irqc_merge #(.NUM_SRC(NUM_SRC)) u_merge (
        .clk      (clk),
        .rst      (rst),
        .pend_i   (pend),
        .ena_i    (ena),
        .masked_o (masked),
        .irq_o    (irq_out)
    );

    always_comb begin
        case (reg_ix_e'(reg_idx))
            IX_IDENT: reg_rdata = ID_CODE;
            IX_CAPS:  reg_rdata = CAPS;
            IX_ENA:   reg_rdata = DATA_W'(ena);
            IX_POL:   reg_rdata = DATA_W'(pol);
            IX_TRIG:  reg_rdata = DATA_W'(trig);
            IX_ACK:   reg_rdata = DATA_W'(pend);
            IX_MASK:  reg_rdata = DATA_W'(masked);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/irq_combiner_bench.sv
`timescale 1ns/1ps
module irq_combiner_bench;
    localparam int          N   = 4;
    localparam logic [31:0] IDC = 32'h5A17_0042;
    localparam logic [31:0] ALL = (32'd1 << N) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] irq_in = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_combiner #(.NUM_SRC(N), .ID_CODE(IDC)) u_irq_combiner (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_we(reg_we),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] ix, input logic [31:0] d);
        reg_we = 1'b1; reg_idx = ix; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] ix, output logic [31:0] d);
        reg_idx = ix;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R3 reset state
        rd(3'd2, v); chk("R3 enable reset", v, 0);
        rd(3'd4, v); chk("R3 polarity reset", v, 0);
        rd(3'd5, v); chk("R3 type reset", v, 0);
        chk("R3 irq low", {31'd0, irq_out}, 0);
        // R1 identity, R2 options
        rd(3'd0, v); chk("R1 identity", v, IDC);
        rd(3'd1, v); chk("R2 options count", v, N);
        rd(3'd3, v); chk("R1 enable-set reads zero", v, 0);
        // R2 bits beyond count ignored
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R2 upper enable bits", v, ALL);
        // R8 enable-set preserves
        wr(3'd2, 32'h4);
        wr(3'd3, 32'h3);
        rd(3'd2, v); chk("R8 enable-set merge", v, 32'h7);
        wr(3'd2, 0);

        // sweep every source, polarity and type
        for (int s = 0; s < N; s++) begin
            for (int p = 0; p < 2; p++) begin
                for (int t = 0; t < 2; t++) begin
                    logic [31:0] m;
                    logic [N-1:0] idle;
                    m = 32'd1 << s;
                    idle = (p != 0) ? m[N-1:0] : '0;
                    irq_in = idle;
                    wr(3'd4, (p != 0) ? m : 0);
                    wr(3'd5, (t != 0) ? m : 0);
                    wr(3'd2, m);
                    tick(2);
                    wr(3'd6, ALL);
                    tick(2);
                    chk("R9 idle irq low", {31'd0, irq_out}, 0);
                    rd(3'd6, v); chk("R4 idle no pending", v, 0);
                    // activate
                    irq_in = idle ^ m[N-1:0];
                    tick(1);
                    rd(3'd6, v); chk("R4 pending after active", v, m);
                    chk("R9 irq not yet", {31'd0, irq_out}, 0);
                    tick(1);
                    chk("R9 irq after two edges", {31'd0, irq_out}, 1);
                    rd(3'd7, v); chk("R10 masked", v, m);
                    if (t != 0) begin
                        wr(3'd6, m);
                        rd(3'd6, v); chk("R7 ack clears edge", v, 0);
                        tick(2);
                        rd(3'd6, v); chk("R5 no retrigger while held", v, 0);
                        chk("R9 irq low after ack", {31'd0, irq_out}, 0);
                        irq_in = idle;
                        tick(2);
                        rd(3'd6, v); chk("R4 inactive edge ignored", v, 0);
                        irq_in = idle ^ m[N-1:0];
                        tick(1);
                        irq_in = idle;
                        tick(2);
                        rd(3'd6, v); chk("R5 edge latched", v, m);
                        chk("R5 irq held", {31'd0, irq_out}, 1);
                        wr(3'd6, ALL & ~m);
                        rd(3'd6, v); chk("R7 zero ack bits", v, m);
                        wr(3'd6, m);
                        tick(1);
                        chk("R7 irq clears", {31'd0, irq_out}, 0);
                    end else begin
                        wr(3'd6, m);
                        rd(3'd6, v); chk("R6 ack ignored while active", v, m);
                        irq_in = idle;
                        tick(1);
                        rd(3'd6, v); chk("R6 level follows", v, 0);
                        tick(1);
                        chk("R6 irq drops", {31'd0, irq_out}, 0);
                    end
                end
            end
        end

        // R10 masking with enable off, then enable-set
        irq_in = '0;
        wr(3'd4, 0);
        wr(3'd5, 32'h1);
        wr(3'd2, 0);
        tick(1);
        wr(3'd6, ALL);
        irq_in = 4'b0001;
        tick(2);
        rd(3'd6, v); chk("R10 raw unmasked", v, 1);
        rd(3'd7, v); chk("R10 masked zero", v, 0);
        chk("R9 disabled irq low", {31'd0, irq_out}, 0);
        wr(3'd3, 32'h1);
        rd(3'd7, v); chk("R8 enable-set masked", v, 1);
        tick(1);
        chk("R9 irq after enable-set", {31'd0, irq_out}, 1);

        // R3 reset again clears control
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        rd(3'd5, v); chk("R3 type after reset", v, 0);
        rd(3'd2, v); chk("R3 enable after reset", v, 0);
        chk("R3 irq after reset", {31'd0, irq_out}, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule